// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This peripheral lets firmware work with a single-bit serial NOR flash through four byte-wide registers. The firmware does not toggle SPI pins itself. It loads a transmit byte and the two lower address bytes, then writes a 4-bit command code. The sequencer builds the matching frame and shifts it out in SPI mode 0, MSB first. A frame is an opcode, optionally followed by a 24-bit address, a data byte, or a dummy byte. The upper address byte is fixed by a parameter to the topmost sector, so the host only supplies the middle and low bytes.

Read, fast-read and page-program open a burst. Chip select stays low after the address, and each "transfer" command shifts one more byte: it sends the transmit register and captures the reply into the receive register. An "end" command closes the burst. Program, erase and status-write operations are followed by automatic status polling until the flash reports that its write is finished. Chip select is always held high for at least two slow SPI periods between frames. A command that arrives while the sequencer is occupied is dropped, and this is recorded in a sticky error flag.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Host register offsets: 0 write loads the transmit byte and 0 read returns the receive byte. 1 write issues a command and 1 read returns status. 2 and 3 write the middle and low address bytes; reading 2 and 3 returns those bytes.
- R2: Command codes and the frames they produce:
  - 1 sends opcode 0x06.
  - 2 sends 0x04.
  - 3 sends 0x05 plus one captured byte.
  - 4 sends 0x01 plus the transmit byte.
  - 5 sends 0x03 plus the address.
  - 6 sends 0x0B plus the address and one dummy byte.
  - 7 sends 0x02 plus the address.
  - 8 sends 0xD8 plus the address.
  - 9 sends 0xC7.
  - Every address is sent as TOP_SECTOR, then the middle byte, then the low byte.
- R3: SPI mode 0. SCK idles low whenever chip select is high. MOSI changes only while SCK is low.
- R4: Each SCK phase lasts SLOW_HALF system clocks. Every frame of a burst opened by code 6 uses FAST_HALF instead.
- R5: Codes 5, 6 and 7 leave chip select low. Code 10 shifts the transmit byte out and captures one byte. Code 11 raises chip select, so the whole burst is a single chip-select-low frame.
- R6: In a program burst, transfers are accepted only while the page offset, counted from the low address byte, is at most 255. A transfer beyond that is ignored and sets the error flag. A transfer issued outside any burst is also ignored with error.
- R7: Status bit 0 (busy) is high while a frame shifts, during the chip-select gap, and while polling is pending. A command written while busy, an unknown code (0, 12 to 15), or a code 1 to 9 issued inside a burst is ignored and sets status bit 4. Bit 4 clears when status is read.
- R8: Chip select stays high for at least 4*SLOW_HALF system clocks between frames.
- R9: After code 4, 8 or 9, or after the end of a program burst, status bit 3 is set. The block then issues 0x05 frames until the flash returns bit 0 clear, clears status bit 3, and leaves busy.
- R10: Status bit 1 is set when a capturing frame (code 3 or 10) ends and clears on a read of offset 0. Status bit 2 clears on a write to offset 0 and sets when code 4 or 10 takes the byte.
- R11: After reset, chip select is high, SCK is low and status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data for the current offset |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
If the frame builder holds a wrong byte, it shows on MOSI within that frame: the opcode byte or an address byte seen by the bench flash model differs. A miscounted page offset shows up as early as the first transfer past the boundary, through the error bit and the length of the program frame. A stuck poll or gap counter shows up as busy never clearing, as the wrong number of status-poll frames, or as a chip-select high time below the minimum. Data reads compare every byte against a pattern derived from the address, so an off-by-one in the dummy byte or the burst offset appears on the first data byte.

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl #(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2,
  parameter logic [7:0] TOP_SECTOR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int HMAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int TW = $clog2(4 * HMAX + 1);
  localparam logic [TW-1:0] GAP = TW'(4 * SLOW_HALF);
  localparam logic [TW-1:0] SLOW_T = TW'(SLOW_HALF - 1);
  localparam logic [TW-1:0] FAST_T = TW'(FAST_HALF - 1);
  localparam logic [3:0] C_XFER = 4'd10, C_END = 4'd11;

  logic [39:0] sh;
  logic [5:0] nbits;
  logic [7:0] rx_sh, rxd, tx_q, mid_q, lo_q;
  logic [8:0] pgcnt;
  logic [TW-1:0] tick, gap;
  logic active, sck_q, cs_q, burst, fast, in_pp, poll_pend, poll_frm;
  logic keep, cap, post_q, wip, err, rxv, txe;

  logic [3:0] code;
  logic c_ok, c_go, c_keep, c_cap, c_post, c_fast, c_pp, c_usetx;
  logic [39:0] c_frame;
  logic [5:0] c_bits;
  logic busy, cmd_wr, accept, reject;

  assign code   = bus_wdata[3:0];
  assign busy   = active | (gap != '0) | poll_pend;
  assign cmd_wr = bus_wr && bus_addr == 2'd1;
  assign accept = cmd_wr && !busy && c_ok;
  assign reject = cmd_wr && (busy || !c_ok);
  assign spi_cs_n = cs_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = sh[39];

  always_comb begin
    c_ok = !burst; c_go = 1'b1; c_keep = 1'b0; c_cap = 1'b0; c_post = 1'b0;
    c_fast = 1'b0; c_pp = 1'b0; c_usetx = 1'b0; c_bits = 6'd8; c_frame = '0;
    case (code)
      4'd1: c_frame = {8'h06, 32'h0};
      4'd2: c_frame = {8'h04, 32'h0};
      4'd3: begin c_frame = {8'h05, 32'h0}; c_bits = 6'd16; c_cap = 1'b1; end
      4'd4: begin c_frame = {8'h01, tx_q, 24'h0}; c_bits = 6'd16; c_post = 1'b1; c_usetx = 1'b1; end
      4'd5: begin c_frame = {8'h03, TOP_SECTOR, mid_q, lo_q, 8'h0}; c_bits = 6'd32; c_keep = 1'b1; end
      4'd6: begin c_frame = {8'h0B, TOP_SECTOR, mid_q, lo_q, 8'h0}; c_bits = 6'd40; c_keep = 1'b1; c_fast = 1'b1; end
      4'd7: begin c_frame = {8'h02, TOP_SECTOR, mid_q, lo_q, 8'h0}; c_bits = 6'd32; c_keep = 1'b1; c_pp = 1'b1; end
      4'd8: begin c_frame = {8'hD8, TOP_SECTOR, mid_q, lo_q, 8'h0}; c_bits = 6'd32; c_post = 1'b1; end
      4'd9: begin c_frame = {8'hC7, 32'h0}; c_post = 1'b1; end
      C_XFER: begin
        c_ok = burst && !(in_pp && pgcnt[8]);
        c_frame = {tx_q, 32'h0}; c_keep = 1'b1; c_cap = 1'b1; c_usetx = 1'b1;
      end
      C_END: begin c_ok = 1'b1; c_go = 1'b0; end
      default: c_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = rxd;
      2'd1: bus_rdata = {3'b000, err, wip, txe, rxv, busy};
      2'd2: bus_rdata = mid_q;
      default: bus_rdata = lo_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; nbits <= '0; rx_sh <= '0; rxd <= '0; tx_q <= '0; mid_q <= '0; lo_q <= '0;
      pgcnt <= '0; tick <= '0; gap <= '0; active <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1;
      burst <= 1'b0; fast <= 1'b0; in_pp <= 1'b0; poll_pend <= 1'b0; poll_frm <= 1'b0;
      keep <= 1'b0; cap <= 1'b0; post_q <= 1'b0; wip <= 1'b0; err <= 1'b0; rxv <= 1'b0; txe <= 1'b1;
    end else begin
      if (bus_wr && bus_addr == 2'd0) begin tx_q <= bus_wdata; txe <= 1'b0; end
      if (bus_wr && bus_addr == 2'd2) mid_q <= bus_wdata;
      if (bus_wr && bus_addr == 2'd3) lo_q <= bus_wdata;
      if (bus_rd && bus_addr == 2'd0) rxv <= 1'b0;
      if (bus_rd && bus_addr == 2'd1) err <= 1'b0;
      if (reject) err <= 1'b1;
      if (gap != '0) gap <= gap - TW'(1);
      if (accept) begin
        if (c_go) begin
          active <= 1'b1; cs_q <= 1'b0; sh <= c_frame; nbits <= c_bits; tick <= '0;
          keep <= c_keep; cap <= c_cap; post_q <= c_post; poll_frm <= 1'b0; burst <= c_keep;
          if (c_fast) fast <= 1'b1;
          if (c_usetx) txe <= 1'b1;
          if (c_pp) begin in_pp <= 1'b1; pgcnt <= {1'b0, lo_q}; end
          else if (code == C_XFER && in_pp) pgcnt <= pgcnt + 9'd1;
        end else if (burst) begin
          cs_q <= 1'b1; gap <= GAP; burst <= 1'b0; fast <= 1'b0; in_pp <= 1'b0;
          if (in_pp) begin poll_pend <= 1'b1; wip <= 1'b1; end
        end
      end else if (active) begin
        if (tick == (fast ? FAST_T : SLOW_T)) begin
          tick <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[6:0], spi_miso};
          end else begin
            sck_q <= 1'b0;
            sh <= {sh[38:0], 1'b0};
            nbits <= nbits - 6'd1;
            if (nbits == 6'd1) begin
              active <= 1'b0;
              if (cap) begin rxd <= rx_sh; rxv <= 1'b1; end
              if (!keep) begin cs_q <= 1'b1; gap <= GAP; end
              if (post_q) begin poll_pend <= 1'b1; wip <= 1'b1; end
              if (poll_frm) begin
                wip <= rx_sh[0];
                if (!rx_sh[0]) poll_pend <= 1'b0;
              end
            end
          end
        end else tick <= tick + TW'(1);
      end else if (poll_pend && gap == '0) begin
        active <= 1'b1; cs_q <= 1'b0; sh <= {8'h05, 32'h0}; nbits <= 6'd16; tick <= '0;
        keep <= 1'b0; cap <= 1'b0; post_q <= 1'b0; poll_frm <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_ctrl_chk.sv
module spi_flash_ctrl_chk #(
  parameter int SLOW_HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       err,
  input logic       active
);
  logic [15:0] csh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csh <= 16'hFFFF;
    else if (!spi_cs_n) csh <= '0;
    else if (csh != 16'hFFFF) csh <= csh + 16'd1;
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> csh >= 16'(4 * SLOW_HALF));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(bus_wr && bus_addr == 2'd1));

  assert_sck_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> (active && !spi_cs_n));
endmodule

bind spi_flash_ctrl spi_flash_ctrl_chk #(.SLOW_HALF(SLOW_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .err(err), .active(active)
);

// File: tb/tb_spi_flash_ctrl.sv
module tb_spi_flash_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 3;
  localparam int FAST = 1;
  localparam int POLLS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  int n_chk = 0, n_fail = 0;

  spi_flash_ctrl #(.SLOW_HALF(SLOW), .FAST_HALF(FAST), .TOP_SECTOR(8'hFF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // flash model
  logic [7:0] fb [16];
  logic [7:0] nb [16];
  int flen = 0, bitc = 0, nlen = 0, nframes = 0, rdsr_n = 0, wip_left = 0;
  logic [7:0] inb = '0, outb = '0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] next_out();
    if (fb[0] == 8'h05) return {7'b1010000, wip_left != 0};
    if (fb[0] == 8'h03 && flen >= 4) return pat({fb[2], fb[3]} + 16'(flen - 4));
    if (fb[0] == 8'h0B && flen >= 5) return pat({fb[2], fb[3]} + 16'(flen - 5));
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) begin flen = 0; bitc = 0; outb = 0; spi_miso = 1'b0; end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    inb = {inb[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (flen < 16) fb[flen] = inb;
      flen++;
      outb = next_out();
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) spi_miso = outb[7 - bitc];

  always @(posedge spi_cs_n) if (flen > 0) begin
    nframes++;
    if (fb[0] == 8'h05) begin
      rdsr_n++;
      if (wip_left > 0) wip_left--;
    end else begin
      for (int i = 0; i < 16; i++) nb[i] = fb[i];
      nlen = flen;
      if (fb[0] == 8'h01 || fb[0] == 8'hD8 || fb[0] == 8'hC7 || fb[0] == 8'h02) wip_left = POLLS;
    end
    flen = 0;
  end

  // timing monitors
  int hcnt = 0, hi_len = 0, ccnt = 0, gmin = 1000000;
  bit seen = 0;
  always @(posedge clk) begin
    if (spi_sck) hcnt++;
    else begin if (hcnt != 0) hi_len = hcnt; hcnt = 0; end
    if (spi_cs_n) ccnt++;
    else begin
      if (seen && ccnt != 0 && ccnt < gmin) gmin = ccnt;
      if (ccnt != 0) seen = 1;
      ccnt = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do rd(2'd1, s); while (s[0]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int f0, p0, allow;
    logic [7:0] mids [2];
    logic [7:0] los [4];
    mids[0] = 8'h12; mids[1] = 8'h80;
    los[0] = 8'h00; los[1] = 8'h7F; los[2] = 8'hFE; los[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd1, s);
    chk("R11 reset status", s, 8'h04);
    chk("R11 reset cs_n", spi_cs_n, 1);
    chk("R11 reset sck", spi_sck, 0);

    wr(2'd2, 8'h12); wr(2'd3, 8'h34);
    rd(2'd2, d); chk("R1 mid readback", d, 8'h12);
    rd(2'd3, d); chk("R1 low readback", d, 8'h34);

    wr(2'd1, 8'd1); wait_idle();
    chk("R2 write-enable len", nlen, 1); chk("R2 write-enable op", nb[0], 8'h06);
    wr(2'd1, 8'd2); wait_idle();
    chk("R2 write-disable op", nb[0], 8'h04);

    p0 = rdsr_n;
    wr(2'd1, 8'd3); wait_idle();
    chk("R2 read-status frame", rdsr_n - p0, 1);
    rd(2'd1, s); chk("R10 rx valid set", s[1], 1);
    rd(2'd0, d); chk("R10 status byte captured", d, 8'hA0);
    rd(2'd1, s); chk("R10 rx valid cleared", s[1], 0);

    foreach (mids[m]) foreach (los[l]) for (int n = 1; n <= 3; n++) begin
      wr(2'd2, mids[m]); wr(2'd3, los[l]);
      f0 = nframes;
      wr(2'd1, 8'd5); wait_idle();
      for (int k = 0; k < n; k++) begin
        wr(2'd1, 8'd10); wait_idle();
        rd(2'd0, d);
        chk("R5 read data", d, pat({mids[m], los[l]} + 16'(k)));
      end
      chk("R5 cs held during burst", nframes - f0, 0);
      wr(2'd1, 8'd11); wait_idle();
      chk("R5 single frame", nframes - f0, 1);
      chk("R5 frame len", nlen, 4 + n);
      chk("R2 read op", nb[0], 8'h03);
      chk("R2 top sector", nb[1], 8'hFF);
      chk("R2 mid", nb[2], mids[m]);
      chk("R2 low", nb[3], los[l]);
      chk("R4 slow half period", hi_len, SLOW);
    end

    wr(2'd2, 8'h05); wr(2'd3, 8'h10);
    wr(2'd1, 8'd6); wait_idle();
    for (int k = 0; k < 2; k++) begin
      wr(2'd1, 8'd10); wait_idle();
      rd(2'd0, d); chk("R2 fast read data after dummy", d, pat(16'h0510 + 16'(k)));
    end
    chk("R4 fast half period", hi_len, FAST);
    wr(2'd1, 8'd11); wait_idle();
    chk("R2 fast read op", nb[0], 8'h0B);
    chk("R2 fast read len", nlen, 7);

    wr(2'd0, 8'h3C);
    rd(2'd1, s); chk("R10 tx empty cleared", s[2], 0);
    p0 = rdsr_n;
    wr(2'd1, 8'd4);
    while (rdsr_n == p0) @(negedge clk);
    rd(2'd1, s); chk("R9 wip and busy during polling", s & 8'h09, 8'h09);
    wait_idle();
    rd(2'd1, s);
    chk("R10 tx empty set", s[2], 1);
    chk("R9 wip cleared", s[3], 0);
    chk("R9 poll count", rdsr_n - p0, POLLS + 1);
    chk("R2 write-status op", nb[0], 8'h01);
    chk("R2 write-status data", nb[1], 8'h3C);

    wr(2'd2, 8'h44); wr(2'd3, 8'h21);
    p0 = rdsr_n;
    wr(2'd1, 8'd8); wait_idle();
    chk("R2 sector erase op", nb[0], 8'hD8);
    chk("R2 sector erase addr", {nb[1], nb[2], nb[3]}, 24'hFF4421);
    chk("R9 erase polls", rdsr_n - p0, POLLS + 1);
    p0 = rdsr_n;
    wr(2'd1, 8'd9); wait_idle();
    chk("R2 bulk erase op", nb[0], 8'hC7);
    chk("R2 bulk erase len", nlen, 1);
    chk("R9 bulk polls", rdsr_n - p0, POLLS + 1);

    for (int lo = 8'hFA; lo <= 8'hFF; lo++) begin
      allow = 256 - lo;
      wr(2'd2, 8'h30); wr(2'd3, 8'(lo));
      p0 = rdsr_n;
      wr(2'd1, 8'd7); wait_idle();
      for (int k = 0; k < 8; k++) begin
        wr(2'd0, 8'hA0 + 8'(k));
        wr(2'd1, 8'd10);
        rd(2'd1, s);
        chk("R6 page boundary error flag", s[4], (k >= allow) ? 1 : 0);
        wait_idle();
      end
      wr(2'd1, 8'd11); wait_idle();
      chk("R6 program frame len", nlen, 4 + allow);
      chk("R2 program op", nb[0], 8'h02);
      for (int j = 0; j < allow; j++) chk("R6 program data", nb[4 + j], 8'hA0 + 8'(j));
      chk("R9 program polls", rdsr_n - p0, POLLS + 1);
      rd(2'd1, s); chk("R9 wip after program", s[3], 0);
    end

    f0 = nframes;
    wr(2'd1, 8'd3); wr(2'd1, 8'd1);
    rd(2'd1, s); chk("R7 busy reject", s & 8'h11, 8'h11);
    wait_idle();
    chk("R7 only one frame", nframes - f0, 1);
    chk("R7 rejected frame absent", nb[0], 8'h02);
    rd(2'd1, s); chk("R7 error cleared on read", s[4], 0);

    f0 = nframes;
    wr(2'd1, 8'd10); rd(2'd1, s); chk("R6 transfer outside burst", s[4], 1);
    wr(2'd1, 8'd15); rd(2'd1, s); chk("R7 unknown code", s[4], 1);
    wr(2'd1, 8'd0);  rd(2'd1, s); chk("R7 code zero", s[4], 1);
    repeat (20) @(negedge clk);
    chk("R7 no frame from rejected", nframes - f0, 0);
    chk("R3 idle sck", spi_sck, 0);

    wr(2'd1, 8'd5); wait_idle();
    wr(2'd1, 8'd1); rd(2'd1, s); chk("R7 command inside burst", s[4], 1);
    wr(2'd1, 8'd11); wait_idle();
    chk("R7 burst frame intact", nb[0], 8'h03);

    chk("R8 chip-select gap", (gmin >= 4 * SLOW) ? 1 : 0, 1);

    summary();
    $finish;
  end
endmodule